// File: doc/BRIEF.md
# Multi-Slot Retire Queue Controller

This block keeps the books for instructions in flight between dispatch and in-order retirement. The queue is a ring of `NUM_SLOTS` slots. An instruction can span several consecutive slots, one for each of its micro-ops. When dispatch asks to reserve slots, the block either grants the request or refuses it. On a grant it hands back a token, which is the ring index of the instruction's first slot. Execution units later present that token to mark the instruction as executed.

On every cycle the retire side looks at the oldest instruction in the ring. If that instruction has executed, the block frees all of its slots, moves the head past it, and then looks at the next instruction. This continues in program order until an instruction has not executed or the per-cycle limit `MAX_RETIRE` is reached. The number of instructions retired appears on `ret_count` in the same cycle the retirement takes effect. Dispatch can watch `free_cnt` to see how many slots are left.

The ring size need not be a power of two. Both the allocation pointer and the head pointer wrap modulo `NUM_SLOTS`.

Top module: `rq_retire_queue`

## Requirements
- R1: After reset, `free_cnt` equals `NUM_SLOTS`, `disp_token` is 0 and `ret_count` is 0.
- R2: The slot count of a request is `disp_uops` limited to at most `NUM_SLOTS`. A request with `disp_uops` = 0 still takes exactly one slot.
- R3: `disp_gnt` is high in the same cycle as `disp_req` only when `free_cnt` is at least the request's slot count. A refused request changes neither `free_cnt` nor `disp_token`.
- R4: `disp_token` always shows the allocation pointer. A grant returns that value as the token, and on the clock edge the pointer advances by the slot count, modulo `NUM_SLOTS`.
- R5: A completion, `done_vld` with `done_token`, marks the instruction that starts at that slot as executed. A newly granted instruction starts as not executed.
- R6: Retirement is in order. It stops at the first instruction, counting from the head, that has not executed, even if younger instructions have executed.
- R7: Retiring an instruction moves the head by that instruction's slot count, modulo `NUM_SLOTS`, and raises `free_cnt` by that count.
- R8: At most `MAX_RETIRE` instructions retire in one cycle. `MAX_RETIRE` = 0 removes the limit.
- R9: When a grant and a retirement fall in the same cycle, `free_cnt` changes by the slots freed minus the slots reserved.
- R10: A completion can first be retired in the cycle after it is reported. `ret_count` is valid in the cycle whose clock edge performs the retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_req | input | 1 | Dispatch asks to reserve slots |
| disp_uops | input | UOP_W | Micro-op count of the dispatching instruction |
| disp_gnt | output | 1 | Reservation granted this cycle |
| disp_token | output | IDX_W | Allocation pointer; the token of a granted request |
| done_vld | input | 1 | An execution unit reports a completion |
| done_token | input | IDX_W | Token of the completed instruction |
| ret_count | output | RCNT_W | Instructions retired at this cycle's edge |
| free_cnt | output | CNT_W | Unreserved slots |

## Verification
The checker assumes that every completion names the first slot of an instruction that is in flight and has not yet executed. It also assumes that dispatch keeps `disp_req` low when no reservation is wanted. The stimulus keeps within these limits by reporting only tokens it has just received, each one exactly once. Where completions arrive out of order, it reports them in reverse so that they pile up behind an older instruction that has not executed.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Ring advance: a < n and b <= n, so a single conditional subtract suffices.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b,
                                           int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/rq_norm.sv
module rq_norm #(
  parameter int NUM_SLOTS = 12,
  parameter int UOP_W     = 4,
  parameter int CNT_W     = 4
) (
  input  logic [UOP_W-1:0] uops,
  output logic [CNT_W-1:0] slots
);

  always_comb begin
    if (uops == '0) begin
      slots = CNT_W'(1);
    end else if (32'(uops) > NUM_SLOTS) begin
      slots = CNT_W'(NUM_SLOTS);
    end else begin
      slots = CNT_W'(uops);
    end
  end

endmodule

// File: rtl/rq_slot_store.sv
module rq_slot_store #(
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [CNT_W-1:0] alloc_size,
  input  logic             done_en,
  input  logic [IDX_W-1:0] done_idx,
  output logic [CNT_W-1:0] sizes [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0] exec_vec
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic             hit_alloc;
    logic             hit_done;
    logic [CNT_W-1:0] size_q;
    logic             exec_q;
    logic             exec_d;

    assign hit_alloc = alloc_en && (32'(alloc_idx) == i);
    assign hit_done  = done_en  && (32'(done_idx)  == i);

    always_comb begin
      exec_d = exec_q;
      if (hit_done)  exec_d = 1'b1;
      if (hit_alloc) exec_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q <= '0;
      end else if (hit_alloc) begin
        size_q <= alloc_size;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        exec_q <= 1'b0;
      end else if (hit_alloc || hit_done) begin
        exec_q <= exec_d;
      end
    end

    assign sizes[i]    = size_q;
    assign exec_vec[i] = exec_q;
  end

endmodule

// File: rtl/rq_retire_pick.sv
module rq_retire_pick #(
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 4,
  parameter int LANES     = 2,
  parameter int RCNT_W    = 2
) (
  input  logic [IDX_W-1:0]     head,
  input  logic [CNT_W-1:0]     used,
  input  logic [NUM_SLOTS-1:0] exec_vec,
  input  logic [CNT_W-1:0]     sizes [NUM_SLOTS],
  output logic [RCNT_W-1:0]    ret_count,
  output logic [CNT_W-1:0]     freed,
  output logic [IDX_W-1:0]     head_nxt
);

  import rq_pkg::*;

  // Walk the ring from the head; each lane retires one instruction if every
  // earlier lane did, it has executed, and it lies inside the occupied span.
  always_comb begin
    logic [IDX_W-1:0]  p;
    logic [CNT_W-1:0]  f;
    logic [RCNT_W-1:0] c;
    logic              go;
    p  = head;
    f  = '0;
    c  = '0;
    go = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      go = go && (f < used) && exec_vec[p];
      if (go) begin
        f = f + sizes[p];
        p = IDX_W'(ring_add(32'(p), 32'(sizes[p]), NUM_SLOTS));
        c = c + RCNT_W'(1);
      end
    end
    ret_count = c;
    freed     = f;
    head_nxt  = p;
  end

endmodule

// File: rtl/rq_retire_queue.sv
module rq_retire_queue #(
  parameter int NUM_SLOTS  = 12,
  parameter int UOP_W      = 4,
  parameter int MAX_RETIRE = 2,
  localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int LANES  = (MAX_RETIRE == 0 || MAX_RETIRE > NUM_SLOTS)
                          ? NUM_SLOTS : MAX_RETIRE,
  localparam int RCNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_req,
  input  logic [UOP_W-1:0]  disp_uops,
  output logic              disp_gnt,
  output logic [IDX_W-1:0]  disp_token,
  input  logic              done_vld,
  input  logic [IDX_W-1:0]  done_token,
  output logic [RCNT_W-1:0] ret_count,
  output logic [CNT_W-1:0]  free_cnt
);

  import rq_pkg::*;

  logic [IDX_W-1:0]  tail_q, tail_d;
  logic [IDX_W-1:0]  head_q, head_d;
  logic [CNT_W-1:0]  free_q, free_d;
  logic [CNT_W-1:0]  req_slots;
  logic [CNT_W-1:0]  used;
  logic [CNT_W-1:0]  freed;
  logic [CNT_W-1:0]  sizes [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] exec_vec;
  logic              upd_en;

  rq_norm #(
    .NUM_SLOTS(NUM_SLOTS), .UOP_W(UOP_W), .CNT_W(CNT_W)
  ) u_norm (
    .uops (disp_uops),
    .slots(req_slots)
  );

  assign disp_gnt = disp_req && (free_q >= req_slots);
  assign used     = CNT_W'(NUM_SLOTS) - free_q;

  rq_slot_store #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (disp_gnt),
    .alloc_idx (tail_q),
    .alloc_size(req_slots),
    .done_en   (done_vld),
    .done_idx  (done_token),
    .sizes     (sizes),
    .exec_vec  (exec_vec)
  );

  rq_retire_pick #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .LANES(LANES), .RCNT_W(RCNT_W)
  ) u_pick (
    .head     (head_q),
    .used     (used),
    .exec_vec (exec_vec),
    .sizes    (sizes),
    .ret_count(ret_count),
    .freed    (freed),
    .head_nxt (head_d)
  );

  always_comb begin
    tail_d = tail_q;
    free_d = free_q + freed;
    if (disp_gnt) begin
      tail_d = IDX_W'(ring_add(32'(tail_q), 32'(req_slots), NUM_SLOTS));
      free_d = free_d - req_slots;
    end
  end

  assign upd_en = disp_gnt || (ret_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
      free_q <= CNT_W'(NUM_SLOTS);
    end else if (upd_en) begin
      tail_q <= tail_d;
      head_q <= head_d;
      free_q <= free_d;
    end
  end

  assign disp_token = tail_q;
  assign free_cnt   = free_q;

endmodule

// File: rtl/rq_retire_queue_chk.sv
module rq_retire_queue_chk #(
  parameter int NUM_SLOTS  = 12,
  parameter int MAX_RETIRE = 2,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 4,
  parameter int RCNT_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_req,
  input logic              disp_gnt,
  input logic [IDX_W-1:0]  disp_token,
  input logic [RCNT_W-1:0] ret_count,
  input logic [CNT_W-1:0]  free_cnt
);

  a_r9_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_cnt) <= NUM_SLOTS);

  a_r4_token_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(disp_token) < NUM_SLOTS);

  a_r3_refusal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && !disp_gnt && ret_count == '0)
      |=> ($stable(free_cnt) && $stable(disp_token)));

  a_r8_retire_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_count != '0) |-> (MAX_RETIRE == 0 || 32'(ret_count) <= MAX_RETIRE));

  a_r6_needs_occupant: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_count != '0) |-> (32'(free_cnt) < NUM_SLOTS));

  a_r7_free_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_gnt && ret_count != '0) |=> (free_cnt > $past(free_cnt)));

endmodule

bind rq_retire_queue rq_retire_queue_chk #(
  .NUM_SLOTS(NUM_SLOTS), .MAX_RETIRE(MAX_RETIRE),
  .IDX_W(IDX_W), .CNT_W(CNT_W), .RCNT_W(RCNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_req  (disp_req),
  .disp_gnt  (disp_gnt),
  .disp_token(disp_token),
  .ret_count (ret_count),
  .free_cnt  (free_cnt)
);

// File: tb/rq_retire_queue_test.sv
`timescale 1ns/1ps
module rq_retire_queue_test;

  logic clk;
  logic rst_n;
  int   checks;
  int   fails;

  // limited instance (MAX_RETIRE = 2)
  logic       disp_req, done_vld, disp_gnt;
  logic [3:0] disp_uops, done_token, disp_token, free_cnt;
  logic [1:0] ret_count;

  // unlimited instance (MAX_RETIRE = 0)
  logic       n_req, n_dv, n_gnt;
  logic [3:0] n_uops, n_dtok, n_tok, n_free, n_ret;

  rq_retire_queue #(.NUM_SLOTS(12), .UOP_W(4), .MAX_RETIRE(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .disp_req(disp_req), .disp_uops(disp_uops),
    .disp_gnt(disp_gnt), .disp_token(disp_token),
    .done_vld(done_vld), .done_token(done_token),
    .ret_count(ret_count), .free_cnt(free_cnt)
  );

  rq_retire_queue #(.NUM_SLOTS(12), .UOP_W(4), .MAX_RETIRE(0)) uut_nl (
    .clk(clk), .rst_n(rst_n),
    .disp_req(n_req), .disp_uops(n_uops),
    .disp_gnt(n_gnt), .disp_token(n_tok),
    .done_vld(n_dv), .done_token(n_dtok),
    .ret_count(n_ret), .free_cnt(n_free)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req, uops[4], done_vld, done_tok[4] | gnt, token[4], ret[2], free[4]}
  localparam int ROWS = 19;
  localparam logic [20:0] TBL [ROWS] = '{
    {1'b1, 4'd3,  1'b0, 4'd0, 1'b1, 4'd0, 2'd0, 4'd12},
    {1'b1, 4'd0,  1'b0, 4'd0, 1'b1, 4'd3, 2'd0, 4'd9},
    {1'b1, 4'd15, 1'b0, 4'd0, 1'b0, 4'd4, 2'd0, 4'd8},
    {1'b1, 4'd5,  1'b1, 4'd3, 1'b1, 4'd4, 2'd0, 4'd8},
    {1'b0, 4'd0,  1'b1, 4'd4, 1'b0, 4'd9, 2'd0, 4'd3},
    {1'b0, 4'd0,  1'b1, 4'd0, 1'b0, 4'd9, 2'd0, 4'd3},
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9, 2'd2, 4'd3},
    {1'b1, 4'd4,  1'b0, 4'd0, 1'b1, 4'd9, 2'd1, 4'd7},
    {1'b1, 4'd9,  1'b0, 4'd0, 1'b0, 4'd1, 2'd0, 4'd8},
    {1'b1, 4'd8,  1'b0, 4'd0, 1'b1, 4'd1, 2'd0, 4'd8},
    {1'b1, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9, 2'd0, 4'd0},
    {1'b0, 4'd0,  1'b1, 4'd1, 1'b0, 4'd9, 2'd0, 4'd0},
    {1'b0, 4'd0,  1'b1, 4'd9, 1'b0, 4'd9, 2'd0, 4'd0},
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9, 2'd2, 4'd0},
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9, 2'd0, 4'd12},
    {1'b1, 4'd12, 1'b0, 4'd0, 1'b1, 4'd9, 2'd0, 4'd12},
    {1'b1, 4'd1,  1'b1, 4'd9, 1'b0, 4'd9, 2'd0, 4'd0},
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9, 2'd1, 4'd0},
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9, 2'd0, 4'd12}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // drive at the falling edge, sample 1 ns later, then let the rising edge act
  task automatic n_step(input logic rq, input logic [3:0] u,
                        input logic dv, input logic [3:0] dt);
    @(negedge clk);
    n_req = rq; n_uops = u; n_dv = dv; n_dtok = dt;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    disp_req = 1'b0; disp_uops = '0; done_vld = 1'b0; done_token = '0;
    n_req = 1'b0; n_uops = '0; n_dv = 1'b0; n_dtok = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 free_cnt", int'(free_cnt), 12);
    chk("R1 disp_token", int'(disp_token), 0);
    chk("R1 ret_count", int'(ret_count), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      disp_req   = TBL[r][20];
      disp_uops  = TBL[r][19:16];
      done_vld   = TBL[r][15];
      done_token = TBL[r][14:11];
      #1;
      chk($sformatf("R2/R3 gnt row %0d", r), int'(disp_gnt), int'(TBL[r][10]));
      chk($sformatf("R4 token row %0d", r), int'(disp_token), int'(TBL[r][9:6]));
      chk($sformatf("R6/R8/R10 ret row %0d", r), int'(ret_count), int'(TBL[r][5:4]));
      chk($sformatf("R7/R9 free row %0d", r), int'(free_cnt), int'(TBL[r][3:0]));
    end
    @(negedge clk);
    disp_req = 1'b0; done_vld = 1'b0;

    // R8 unlimited mode: three one-slot instructions, completed youngest first
    n_step(1'b1, 4'd1, 1'b0, 4'd0);
    chk("R4 nl token 0", int'(n_tok), 0);
    n_step(1'b1, 4'd0, 1'b0, 4'd0);
    chk("R2 nl zero-uop token", int'(n_tok), 1);
    n_step(1'b1, 4'd1, 1'b0, 4'd0);
    chk("R4 nl token 2", int'(n_tok), 2);
    n_step(1'b0, 4'd0, 1'b1, 4'd2);
    chk("R2 nl free after three", int'(n_free), 9);
    n_step(1'b0, 4'd0, 1'b1, 4'd1);
    chk("R6 nl blocked by head", int'(n_ret), 0);
    n_step(1'b0, 4'd0, 1'b1, 4'd0);
    chk("R10 nl not same cycle", int'(n_ret), 0);
    n_step(1'b0, 4'd0, 1'b0, 4'd0);
    chk("R8 nl retire all three", int'(n_ret), 3);
    chk("R5 nl free before edge", int'(n_free), 9);
    n_step(1'b0, 4'd0, 1'b0, 4'd0);
    chk("R7 nl free restored", int'(n_free), 12);
    chk("R7 nl ret idle", int'(n_ret), 0);

    // R1 reset from a busy state
    @(negedge clk);
    disp_req = 1'b1; disp_uops = 4'd6;
    @(negedge clk);
    disp_req = 1'b0;
    #1;
    chk("R1 pre-reset free", int'(free_cnt), 6);
    rst_n = 1'b0;
    #1;
    chk("R1 async free", int'(free_cnt), 12);
    chk("R1 async token", int'(disp_token), 0);
    @(negedge clk);
    rst_n = 1'b1;
    disp_req = 1'b1; disp_uops = 4'd13;
    #1;
    chk("R2 clamp to ring grants", int'(disp_gnt), 1);
    @(negedge clk);
    disp_req = 1'b0;
    #1;
    chk("R2 clamp free", int'(free_cnt), 0);
    chk("R4 full-ring wrap token", int'(disp_token), 0);

    finish_run();
  end

endmodule